// File: doc/BRIEF.md
# PC Card Socket Window Decoder

This block is the address-decode core of a PC card socket controller. Host software programs it through two byte-wide ports: an index port that selects a register and a data port that reads or writes the selected register. Each socket has a 64-byte register space. It holds power and card-control bits, an interrupt number, a window-enable byte, an I/O control byte, two I/O windows and a set of memory map windows.

On every host cycle presented on the access inputs, the block checks the enabled windows of the addressed socket. One cycle later it reports whether a window claimed the cycle. For a claimed cycle it also gives the card-side address, whether attribute or common memory is targeted, whether the data path is 16 bits wide, and the zero-wait and timing-set choices of that window. I/O cycles pass the host address through unchanged. Memory cycles are relocated by a 4 KiB-granular offset that wraps at 32 MiB.

Top module: `pcsock_win_dec`

## Requirements
- R1: A data-port write with `port_sel`=1 writes the register selected by the last index-port write (`port_sel`=0), and a data-port read returns that register on `port_rdata` one cycle later. A read with `port_sel`=0 returns the index. Index bits 7:6 give the socket and bits 5:0 the register offset. Indexes whose socket is NSOCK or above read 0 and ignore writes.
- R2: Offset 0x00 reads as 0x8 in bits 7:4 and the nonzero REV in bits 3:0, and writes to it are ignored.
- R3: After reset every register, the index and `port_rdata` are zero, `dec_hit` is 0 and every `sock_hold_rst` bit is 1.
- R4: I/O window w (w=0,1) has its start at offsets 0x08+4w (low byte) and 0x09+4w (high byte), and its stop at 0x0A+4w and 0x0B+4w. It is enabled by bit 6+w of offset 0x06. An I/O cycle with start <= addr[15:0] <= stop is claimed on the next cycle, with `dec_caddr` = addr[15:0] zero-extended and `dec_attr`=0.
- R5: For a claimed I/O cycle, nibble w of offset 0x07 (bits 4w+3:4w) applies. Its bit 0 sets `dec_w16`. Its bit 1 sets `dec_w16` when `card_req16` is 1. Its bit 2 drives `dec_zws` and its bit 3 drives `dec_tset`.
- R6: Memory map m (0 <= m < NMEM) uses offsets 0x10+8m..0x15+8m: start page {byte1[3:0],byte0}, stop page {byte3[3:0],byte2}, and offset {byte5[4:0],byte4}. It is enabled by bit m of offset 0x06. A memory cycle with start <= addr[23:12] <= stop is claimed.
- R7: For a claimed memory cycle, `dec_caddr` = {(addr[23:12] + offset) mod 2^13, addr[11:0]}.
- R8: For a claimed memory cycle, byte1 bit 7 drives `dec_w16`, byte3 bit 6 drives `dec_tset`, byte5 bit 6 drives `dec_attr`, and `dec_zws` is 0.
- R9: When several enabled windows of the cycle's type match, the lowest-numbered one is used.
- R10: A cycle that no enabled window claims, or a cycle with no `acc_valid`, gives all-zero decode outputs on the next cycle.
- R11: Offset 0x03 bits 3:0 drive `sock_irq`, bit 5 drives `sock_io_card`, and bit 6 low asserts `sock_hold_rst`. Offset 0x02 bit 7 drives `sock_out_en`, bit 5 drives `sock_auto_pwr` and bit 4 drives `sock_card_en`.
- R12: Offsets 0x01, 0x04, 0x05, bytes 6 and 7 of each memory map, and offsets past the last map read 0 and ignore writes. All other offsets read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Host write strobe to the index/data ports |
| port_rd | input | 1 | Host read strobe to the index/data ports |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Registered read data |
| acc_valid | input | 1 | A host cycle is presented for decode |
| acc_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| acc_sock | input | SW | Socket addressed by the cycle |
| acc_addr | input | 24 | Host address (I/O uses bits 15:0) |
| card_req16 | input | 1 | Card requests a 16-bit transfer |
| dec_hit | output | 1 | The cycle was claimed by a window |
| dec_caddr | output | 25 | Card-side address |
| dec_attr | output | 1 | Attribute memory selected |
| dec_w16 | output | 1 | 16-bit data path |
| dec_tset | output | 1 | Timing set 1 selected |
| dec_zws | output | 1 | Zero wait states |
| sock_irq | output | 4*NSOCK | Programmed interrupt number per socket |
| sock_hold_rst | output | NSOCK | Card held in reset |
| sock_io_card | output | NSOCK | Socket configured for an I/O card |
| sock_out_en | output | NSOCK | Socket outputs enabled |
| sock_auto_pwr | output | NSOCK | Automatic power switching selected |
| sock_card_en | output | NSOCK | Card enable |

## Verification
The assertions assume that a host never drives a port access and a decode cycle that depends on the same register in one cycle. The properties that tie the decode outputs to the past cycle also assume that `acc_addr` and `acc_io` are held only while `acc_valid` is meaningful. The stimulus drives every input at the falling edge and programs windows before it presents cycles against them. In the random phase, writes and accesses may share a cycle. This is legal, because decode uses the register values that stand before the edge, and the reference model mirrors that ordering.

// File: rtl/pcsw_pkg.sv
package pcsw_pkg;
  localparam int REGS_PER_SOCK = 64;
  localparam int MAP_BASE      = 16;
  localparam int MAP_STRIDE    = 8;
  localparam int OFS_WEN       = 6;
  localparam int OFS_IOCTL     = 7;
  localparam int IO_BASE       = 8;
  localparam int CADDR_W       = 25;
  localparam int PAGE_W        = 12;
  localparam int CPAGE_W       = 13;

  typedef struct packed {
    logic               hit;
    logic [CADDR_W-1:0] caddr;
    logic               attr;
    logic               w16;
    logic               tset;
    logic               zws;
  } dec_t;

  function automatic logic reg_implemented(input logic [5:0] ofs, input int nmem);
    int o;
    o = int'(ofs);
    if (o == 2 || o == 3 || o == OFS_WEN || o == OFS_IOCTL) return 1'b1;
    if (o >= IO_BASE && o < MAP_BASE) return 1'b1;
    if (o >= MAP_BASE && o < MAP_BASE + MAP_STRIDE * nmem && ofs[2:0] < 3'd6) return 1'b1;
    return 1'b0;
  endfunction
endpackage

// File: rtl/pcsw_regfile.sv
module pcsw_regfile
  import pcsw_pkg::*;
#(
  parameter int         NSOCK = 2,
  parameter int         NMEM  = 5,
  parameter logic [3:0] REV   = 4'h2
) (
  input  logic clk,
  input  logic rst,
  input  logic port_wr,
  input  logic port_rd,
  input  logic port_sel,
  input  logic [7:0] port_wdata,
  output logic [7:0] port_rdata,
  output logic [NSOCK-1:0][REGS_PER_SOCK-1:0][7:0] regs_o
);
  logic [7:0] idx_q;
  logic [NSOCK-1:0][REGS_PER_SOCK-1:0][7:0] regs_q;
  logic [1:0] isock;
  logic [5:0] iofs;
  logic       sock_ok;
  logic       wr_ok;
  logic [7:0] rd_val;

  assign isock  = idx_q[7:6];
  assign iofs   = idx_q[5:0];
  assign sock_ok = int'(isock) < NSOCK;
  assign wr_ok  = sock_ok && reg_implemented(iofs, NMEM);
  assign regs_o = regs_q;

  always_comb begin
    rd_val = 8'h00;
    for (int s = 0; s < NSOCK; s++) begin
      if (isock == 2'(s)) begin
        if (iofs == 6'h00)                  rd_val = {4'h8, REV};
        else if (reg_implemented(iofs, NMEM)) rd_val = regs_q[s][iofs];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= 8'h00;
      regs_q     <= '0;
      port_rdata <= 8'h00;
    end else begin
      if (port_wr && !port_sel) idx_q <= port_wdata;
      if (port_wr && port_sel && wr_ok) begin
        for (int s = 0; s < NSOCK; s++)
          if (isock == 2'(s)) regs_q[s][iofs] <= port_wdata;
      end
      if (port_rd) port_rdata <= port_sel ? rd_val : idx_q;
    end
  end

  // R2: identification byte format
  assert_id_R2: assert property (@(posedge clk) disable iff (rst)
    port_rd && port_sel && sock_ok && iofs == 6'h00 |=>
      port_rdata[7:4] == 4'h8 && port_rdata[3:0] != 4'h0);

  // R3: reset clears index and read data
  assert_reset_R3: assert property (@(posedge clk)
    rst |=> idx_q == 8'h00 && port_rdata == 8'h00);

  // R1: socket past NSOCK reads as zero
  assert_badsock_R1: assert property (@(posedge clk) disable iff (rst)
    port_rd && port_sel && !sock_ok |=> port_rdata == 8'h00);
endmodule

// File: rtl/pcsw_io_win.sv
module pcsw_io_win #(
  parameter int AW = 16
) (
  input  logic          en,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] stop,
  input  logic [AW-1:0] addr,
  output logic          match
);
  assign match = en && (addr >= start) && (addr <= stop);
endmodule

// File: rtl/pcsw_mem_win.sv
module pcsw_mem_win
  import pcsw_pkg::*;
(
  input  logic               en,
  input  logic [PAGE_W-1:0]  page,
  input  logic [PAGE_W-1:0]  start,
  input  logic [PAGE_W-1:0]  stop,
  input  logic [CPAGE_W-1:0] offset,
  output logic               match,
  output logic [CPAGE_W-1:0] cpage
);
  assign match = en && (page >= start) && (page <= stop);
  assign cpage = {1'b0, page} + offset;
endmodule

// File: rtl/pcsock_win_dec.sv
module pcsock_win_dec
  import pcsw_pkg::*;
#(
  parameter int         NSOCK = 2,
  parameter int         NMEM  = 5,
  parameter logic [3:0] REV   = 4'h2,
  localparam int        SW    = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 port_wr,
  input  logic                 port_rd,
  input  logic                 port_sel,
  input  logic [7:0]           port_wdata,
  output logic [7:0]           port_rdata,
  input  logic                 acc_valid,
  input  logic                 acc_io,
  input  logic [SW-1:0]        acc_sock,
  input  logic [23:0]          acc_addr,
  input  logic                 card_req16,
  output logic                 dec_hit,
  output logic [CADDR_W-1:0]   dec_caddr,
  output logic                 dec_attr,
  output logic                 dec_w16,
  output logic                 dec_tset,
  output logic                 dec_zws,
  output logic [NSOCK*4-1:0]   sock_irq,
  output logic [NSOCK-1:0]     sock_hold_rst,
  output logic [NSOCK-1:0]     sock_io_card,
  output logic [NSOCK-1:0]     sock_out_en,
  output logic [NSOCK-1:0]     sock_auto_pwr,
  output logic [NSOCK-1:0]     sock_card_en
);
  logic [NSOCK-1:0][REGS_PER_SOCK-1:0][7:0] regs;
  logic [REGS_PER_SOCK-1:0][7:0] sr;
  logic sock_ok;
  logic [1:0] io_m;
  logic [NMEM-1:0] mem_m;
  logic [NMEM-1:0][CPAGE_W-1:0] mem_pg;
  dec_t nxt, dq;
  logic unused_regs;

  pcsw_regfile #(.NSOCK(NSOCK), .NMEM(NMEM), .REV(REV)) u_rf (
    .clk(clk), .rst(rst), .port_wr(port_wr), .port_rd(port_rd),
    .port_sel(port_sel), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .regs_o(regs)
  );

  // socket select for the decode path
  always_comb begin
    sr = '0;
    sock_ok = 1'b0;
    for (int s = 0; s < NSOCK; s++) begin
      if (acc_sock == SW'(s)) begin
        sr = regs[s];
        sock_ok = 1'b1;
      end
    end
  end
  assign unused_regs = ^sr;

  for (genvar w = 0; w < 2; w++) begin : g_io
    localparam int B = IO_BASE + 4 * w;
    pcsw_io_win #(.AW(16)) u_win (
      .en(sr[OFS_WEN][6+w]),
      .start({sr[B+1], sr[B]}),
      .stop({sr[B+3], sr[B+2]}),
      .addr(acc_addr[15:0]),
      .match(io_m[w])
    );
  end

  for (genvar m = 0; m < NMEM; m++) begin : g_map
    localparam int B = MAP_BASE + MAP_STRIDE * m;
    pcsw_mem_win u_map (
      .en(sr[OFS_WEN][m]),
      .page(acc_addr[23:12]),
      .start({sr[B+1][3:0], sr[B]}),
      .stop({sr[B+3][3:0], sr[B+2]}),
      .offset({sr[B+5][4:0], sr[B+4]}),
      .match(mem_m[m]),
      .cpage(mem_pg[m])
    );
  end

  // priority pick: scan high to low so the lowest match lands last
  always_comb begin
    logic [3:0] nib;
    int b;
    nxt = '0;
    nib = 4'h0;
    b   = 0;
    if (acc_valid && sock_ok) begin
      if (acc_io) begin
        for (int w = 1; w >= 0; w--) begin
          if (io_m[w]) begin
            nib       = sr[OFS_IOCTL][4*w +: 4];
            nxt.hit   = 1'b1;
            nxt.caddr = {9'd0, acc_addr[15:0]};
            nxt.attr  = 1'b0;
            nxt.w16   = nib[0] | (nib[1] & card_req16);
            nxt.zws   = nib[2];
            nxt.tset  = nib[3];
          end
        end
      end else begin
        for (int m = NMEM - 1; m >= 0; m--) begin
          if (mem_m[m]) begin
            b         = MAP_BASE + MAP_STRIDE * m;
            nxt.hit   = 1'b1;
            nxt.caddr = {mem_pg[m], acc_addr[11:0]};
            nxt.w16   = sr[b+1][7];
            nxt.tset  = sr[b+3][6];
            nxt.attr  = sr[b+5][6];
            nxt.zws   = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dq <= '0;
    else     dq <= nxt;
  end

  assign dec_hit   = dq.hit;
  assign dec_caddr = dq.caddr;
  assign dec_attr  = dq.attr;
  assign dec_w16   = dq.w16;
  assign dec_tset  = dq.tset;
  assign dec_zws   = dq.zws;

  for (genvar s = 0; s < NSOCK; s++) begin : g_ctl
    assign sock_irq[4*s +: 4] = regs[s][3][3:0];
    assign sock_io_card[s]    = regs[s][3][5];
    assign sock_hold_rst[s]   = ~regs[s][3][6];
    assign sock_out_en[s]     = regs[s][2][7];
    assign sock_auto_pwr[s]   = regs[s][2][5];
    assign sock_card_en[s]    = regs[s][2][4];
  end

  // R3: nothing claimed right after reset
  assert_reset_R3: assert property (@(posedge clk) rst |=> !dec_hit);

  // R10: no cycle presented, nothing claimed
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !dec_hit && dec_caddr == '0);

  // R4: I/O cycles pass the address through as common space
  assert_io_addr_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_io |=>
      !dec_hit || (dec_caddr == {9'd0, $past(acc_addr[15:0])} && !dec_attr));

  // R7: low 12 address bits are never relocated
  assert_mem_low_R7: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_io |=> !dec_hit || dec_caddr[11:0] == $past(acc_addr[11:0]));

  // R9: window 0 wins when it matches
  assert_prio_R9: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_io && sock_ok && io_m[0] |=>
      dec_hit && dec_zws == $past(sr[OFS_IOCTL][2]) && dec_tset == $past(sr[OFS_IOCTL][3]));

  // R8: memory cycles never report zero wait
  assert_mem_zws_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_io |=> !dec_zws);
endmodule

// File: tb/sim_pcsock_win_dec.sv
`timescale 1ns/1ps
module sim_pcsock_win_dec;
  localparam int NS = 2;
  localparam int NM = 5;
  localparam logic [3:0] REV = 4'h2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic port_wr = 0, port_rd = 0, port_sel = 0;
  logic [7:0] port_wdata = 0;
  wire  [7:0] port_rdata;
  logic acc_valid = 0, acc_io = 0;
  logic [0:0] acc_sock = 0;
  logic [23:0] acc_addr = 0;
  logic card_req16 = 0;
  wire dec_hit, dec_attr, dec_w16, dec_tset, dec_zws;
  wire [24:0] dec_caddr;
  wire [NS*4-1:0] sock_irq;
  wire [NS-1:0] sock_hold_rst, sock_io_card, sock_out_en, sock_auto_pwr, sock_card_en;

  pcsock_win_dec #(.NSOCK(NS), .NMEM(NM), .REV(REV)) u0 (.*);

  int vectors = 0, fails = 0;
  bit done = 0;

  // reference model state
  int mr [0:NS-1][0:63];
  int midx = 0, mrd = 0;
  int e_hit, e_ca, e_at, e_w, e_ts, e_zw;

  function automatic bit m_impl(int o);
    if (o == 2 || o == 3 || o == 6 || o == 7) return 1;
    if (o >= 8 && o <= 15) return 1;
    if (o >= 16 && o < 16 + 8 * NM && (o % 8) < 6) return 1;
    return 0;
  endfunction

  task automatic m_decode();
    e_hit = 0; e_ca = 0; e_at = 0; e_w = 0; e_ts = 0; e_zw = 0;
    if (rst || !acc_valid || int'(acc_sock) >= NS) return;
    begin
      int s, wen;
      s = int'(acc_sock);
      wen = mr[s][6];
      if (acc_io) begin
        for (int w = 0; w < 2; w++) begin
          int st, sp, a, nib;
          st = mr[s][8+4*w] + 256 * mr[s][9+4*w];
          sp = mr[s][10+4*w] + 256 * mr[s][11+4*w];
          a = int'(acc_addr[15:0]);
          if (((wen >> (6 + w)) & 1) == 1 && a >= st && a <= sp) begin
            nib = (mr[s][7] >> (4 * w)) & 15;
            e_hit = 1; e_ca = a;
            e_w = ((nib & 1) != 0 || ((nib & 2) != 0 && card_req16)) ? 1 : 0;
            e_zw = (nib >> 2) & 1; e_ts = (nib >> 3) & 1;
            break;
          end
        end
      end else begin
        for (int m = 0; m < NM; m++) begin
          int b, st, sp, off, pg;
          b = 16 + 8 * m;
          st = mr[s][b] + 256 * (mr[s][b+1] & 15);
          sp = mr[s][b+2] + 256 * (mr[s][b+3] & 15);
          off = mr[s][b+4] + 256 * (mr[s][b+5] & 31);
          pg = int'(acc_addr[23:12]);
          if (((wen >> m) & 1) == 1 && pg >= st && pg <= sp) begin
            e_hit = 1;
            e_ca = ((pg + off) % 8192) * 4096 + int'(acc_addr[11:0]);
            e_w = (mr[s][b+1] >> 7) & 1;
            e_ts = (mr[s][b+3] >> 6) & 1;
            e_at = (mr[s][b+5] >> 6) & 1;
            break;
          end
        end
      end
    end
  endtask

  function automatic int m_read();
    int s, o;
    s = midx / 64; o = midx % 64;
    if (s >= NS) return 0;
    if (o == 0) return 'h80 + int'(REV);
    if (m_impl(o)) return mr[s][o];
    return 0;
  endfunction

  task automatic cmp(string tag, string what, int got, int exp);
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic tick(string tag);
    m_decode();
    if (rst) begin
      for (int s = 0; s < NS; s++) for (int o = 0; o < 64; o++) mr[s][o] = 0;
      midx = 0; mrd = 0;
    end else begin
      if (port_rd) mrd = port_sel ? m_read() : midx;
      if (port_wr && !port_sel) midx = int'(port_wdata);
      else if (port_wr && port_sel && midx / 64 < NS && m_impl(midx % 64))
        mr[midx / 64][midx % 64] = int'(port_wdata);
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    cmp(tag, "dec_hit", dec_hit, e_hit);
    cmp(tag, "dec_caddr", dec_caddr, e_ca);
    cmp(tag, "dec_attr", dec_attr, e_at);
    cmp(tag, "dec_w16", dec_w16, e_w);
    cmp(tag, "dec_tset", dec_tset, e_ts);
    cmp(tag, "dec_zws", dec_zws, e_zw);
    cmp(tag, "port_rdata", port_rdata, mrd);
    for (int s = 0; s < NS; s++) begin
      cmp("R11", "sock_irq", sock_irq[4*s +: 4], mr[s][3] & 15);
      cmp("R11", "sock_io_card", sock_io_card[s], (mr[s][3] >> 5) & 1);
      cmp("R11", "sock_hold_rst", sock_hold_rst[s], ((mr[s][3] >> 6) & 1) ^ 1);
      cmp("R11", "sock_out_en", sock_out_en[s], (mr[s][2] >> 7) & 1);
      cmp("R11", "sock_auto_pwr", sock_auto_pwr[s], (mr[s][2] >> 5) & 1);
      cmp("R11", "sock_card_en", sock_card_en[s], (mr[s][2] >> 4) & 1);
    end
  endtask

  task automatic pw(bit sel, int v, string tag);
    port_wr = 1; port_sel = sel; port_wdata = 8'(v);
    tick(tag);
    port_wr = 0;
  endtask

  task automatic setreg(int idx, int v, string tag);
    pw(0, idx, tag);
    pw(1, v, tag);
  endtask

  task automatic getreg(int idx, string tag);
    pw(0, idx, tag);
    port_rd = 1; port_sel = 1;
    tick(tag);
    port_rd = 0;
  endtask

  task automatic acc(bit io, int s, int a, bit rq, string tag);
    acc_valid = 1; acc_io = io; acc_sock = 1'(s); acc_addr = 24'(a); card_req16 = rq;
    tick(tag);
    acc_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick("R3"); tick("R3");
    rst = 0;
    tick("R3");
    cmp("R3", "hold_rst", sock_hold_rst, 2'b11);
    cmp("R3", "hit", dec_hit, 0);

    // identification
    getreg('h00, "R2");
    cmp("R2", "id", port_rdata, 'h82);
    setreg('h40, 'h11, "R2");
    getreg('h40, "R2");
    cmp("R2", "id after write", port_rdata, 'h82);

    // index port readback and unknown socket
    pw(0, 'h9A, "R1");
    port_rd = 1; port_sel = 0; tick("R1"); port_rd = 0;
    cmp("R1", "index read", port_rdata, 'h9A);
    setreg('h88, 'h55, "R1");
    getreg('h88, "R1");
    cmp("R1", "bad socket", port_rdata, 0);

    // I/O windows on socket 0
    setreg('h08, 'h00, "R4"); setreg('h09, 'h03, "R4");
    setreg('h0A, 'h1F, "R4"); setreg('h0B, 'h03, "R4");
    setreg('h0C, 'h10, "R4"); setreg('h0D, 'h03, "R4");
    setreg('h0E, 'hFF, "R4"); setreg('h0F, 'h03, "R4");
    setreg('h07, 'hE1, "R5");
    getreg('h0E, "R12");
    cmp("R12", "readback", port_rdata, 'hFF);
    acc(1, 0, 'h0300, 0, "R10");
    cmp("R10", "disabled window", dec_hit, 0);
    setreg('h06, 'hC0, "R4");
    acc(1, 0, 'h02FF, 0, "R4");
    cmp("R4", "below start", dec_hit, 0);
    acc(1, 0, 'h0300, 0, "R4");
    cmp("R4", "start edge", dec_hit, 1);
    acc(1, 0, 'h031F, 0, "R4");
    cmp("R4", "caddr", dec_caddr, 'h031F);
    acc(1, 0, 'h0310, 0, "R9");
    cmp("R9", "overlap zws", dec_zws, 0);
    cmp("R5", "force16", dec_w16, 1);
    acc(1, 0, 'h0320, 0, "R5");
    cmp("R5", "card decides 0", dec_w16, 0);
    cmp("R5", "zws", dec_zws, 1);
    acc(1, 0, 'h0320, 1, "R5");
    cmp("R5", "card decides 1", dec_w16, 1);
    acc(1, 0, 'h03FF, 0, "R4");
    acc(1, 0, 'h0400, 0, "R10");
    cmp("R10", "above stop", dec_hit, 0);
    acc(0, 0, 'h0D1000, 0, "R10");

    // memory maps on socket 1
    setreg('h50, 'hD0, "R6"); setreg('h51, 'h80, "R8");
    setreg('h52, 'hD3, "R6"); setreg('h53, 'h00, "R6");
    setreg('h54, 'h30, "R7"); setreg('h55, 'h5F, "R8");
    setreg('h58, 'hD2, "R6"); setreg('h59, 'h00, "R6");
    setreg('h5A, 'hFF, "R6"); setreg('h5B, 'h40, "R8");
    setreg('h5C, 'h10, "R7"); setreg('h5D, 'h00, "R7");
    setreg('h70, 'hFF, "R6"); setreg('h71, 'h0F, "R6");
    setreg('h72, 'hFF, "R6"); setreg('h73, 'h0F, "R6");
    setreg('h74, 'hFF, "R7"); setreg('h75, 'h1F, "R7");
    setreg('h46, 'h13, "R6");
    acc(0, 1, 'h0D1234, 0, "R7");
    cmp("R7", "relocated", dec_caddr, 'h001234);
    cmp("R8", "attr", dec_attr, 1);
    cmp("R8", "w16", dec_w16, 1);
    acc(0, 1, 'h0D2000, 0, "R9");
    cmp("R9", "lowest map", dec_caddr, 'h002000);
    acc(0, 1, 'h0E0010, 0, "R7");
    cmp("R7", "map1", dec_caddr, 'h0F0010);
    cmp("R8", "tset", dec_tset, 1);
    acc(0, 1, 'hFFF00A, 0, "R7");
    cmp("R7", "wrap", dec_caddr, 'h0FFE00A);
    acc(0, 1, 'h0CF000, 0, "R6");
    cmp("R6", "below map", dec_hit, 0);
    acc(1, 1, 'h0300, 0, "R10");

    // control bytes
    setreg('h43, 'h65, "R11");
    setreg('h42, 'hB0, "R11");
    cmp("R11", "irq", sock_irq[7:4], 5);
    cmp("R11", "hold", sock_hold_rst[1], 0);

    // unimplemented offsets
    setreg('h01, 'hAA, "R12"); setreg('h04, 'hAA, "R12");
    setreg('h16, 'hAA, "R12"); setreg('h38, 'hAA, "R12");
    getreg('h16, "R12");
    cmp("R12", "map byte6", port_rdata, 0);
    getreg('h38, "R12");
    getreg('h01, "R12");
    getreg('h04, "R12");

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) begin
        int s, o;
        s = int'($urandom_range(0, 1));
        o = int'($urandom_range(2, 55));
        setreg(s * 64 + o, int'($urandom_range(0, 255)), "R9");
      end else if (op == 3) begin
        getreg(int'($urandom_range(0, 255)), "R12");
      end else begin
        acc_valid = 1;
        acc_io = 1'($urandom_range(0, 1));
        acc_sock = 1'($urandom_range(0, 1));
        card_req16 = 1'($urandom_range(0, 1));
        if (acc_io) acc_addr = 24'($urandom_range(0, 'h1FF) + 'h280);
        else acc_addr = {4'h0, 8'($urandom_range(0, 255)), 12'($urandom)};
        if ($urandom_range(0, 3) == 0) begin
          port_wr = 1; port_sel = 1; port_wdata = 8'($urandom);
        end
        tick("R9");
        acc_valid = 0; port_wr = 0;
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule